// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and drives two interrupt lines to a processor: a fast line (FIQ) and a normal line (IRQ). Each request is the OR of a hardware input and a bit that software can set. A select mask sends each source to one line or the other. An enable mask gates the normal line only. Software reaches every register through a simple word-wide read/write port.

For the normal line, a set of programmable vector slots assigns priorities. Each slot names one source and holds a handler address, and slot 0 ranks highest. The block keeps a current priority level in hardware. A handler reads the vector register at its entry. That read returns the handler address and raises the level, so only sources of higher rank can interrupt again. The level that was active before is saved. A write to the same register at handler exit restores the saved level, so nested handlers unwind in order without software bookkeeping. Sources that no enabled slot names are served at a default level and use a default address.

Top module: `vic_nest_top`

## Requirements
- R1: The raw request word (word offset 0x08) is `src_req` OR the soft register. A write to 0x18 ORs data into the soft register and a write to 0x1C clears the bits that are set in the data. A read of 0x18 returns the soft register.
- R2: A read of 0x00 returns raw AND enable AND NOT select. A read of 0x04 returns raw AND select. `fiq_o` is high in the cycle after FIQ status is nonzero.
- R3: A write to 0x10 sets bits of the enable mask and a write to 0x14 clears them. A read of 0x10 returns the mask. 0x0C holds the select mask, where a 1 routes that source to FIQ.
- R4: A slot control word (0x200 + 4·n) uses bit 5 as the slot enable and bits 4:0 as the source number. Its slot address sits at 0x100 + 4·n. The level values are 0..15 (slot n), 16 (default level) and 17 (idle). The level is idle after reset.
- R5: `irq_o` is high in the cycle after either of two conditions holds. The first is that the level is idle and IRQ status is nonzero. The second is that some enabled slot numbered below the current level names a source whose IRQ-status bit is set.
- R6: A read of 0x30 moves the level to the lowest-numbered enabled slot whose source has its IRQ-status bit set, if that slot outranks the current level. The read saves the old level for the new one and returns the slot address. If no such slot outranks the current level, the level stays and the read returns the address of the current level.
- R7: A read of 0x30 with IRQ status zero at the idle level returns the default address. If only sources that no slot names are pending, a read at the idle level sets the level to 16 and returns the default address.
- R8: Any write to 0x30 restores the level saved for the current level. The data is ignored, and nothing happens at the idle level.
- R9: The default address register at 0x34 is readable and writable.
- R10: Reads of 0xFE0..0xFFC return 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word. Undefined offsets read as zero. Writes to 0x00 change nothing.
- R11: After reset all masks, the soft register, slot controls, slot addresses, the default address and the protection bit (bit 0 of 0x20) are zero. Read data is valid in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_req | input | 32 | Hardware request inputs |
| irq_o | output | 1 | Normal interrupt output, registered |
| fiq_o | output | 1 | Fast interrupt output, registered |

## Verification
The hardest state to reach is a nesting of two levels that then unwinds. Reaching it needs a sequence: a lower-ranked source is taken first, a higher-ranked source arrives while its handler is active, and each exit write must bring back exactly the level that was saved. The level cannot be read directly. The bench therefore infers it from `irq_o`, which is sensitive to the level, and from the address that repeated vector reads return. A separate case covers a pending source that no slot names, which must land on the default level and still allow slot sources to preempt it.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_N   = 32;
  localparam int SRC_SELW = $clog2(SRC_N);
  localparam int CTL_W   = SRC_SELW + 1;
  localparam logic [7:0] ID_BYTES [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
endpackage

// File: rtl/vic_slot_arb.sv
module vic_slot_arb #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_N     = 32,
  parameter int SW        = $clog2(SRC_N),
  parameter int LW        = $clog2(NUM_SLOTS + 2)
) (
  input  logic [NUM_SLOTS-1:0]        slot_en,
  input  logic [NUM_SLOTS-1:0][SW-1:0] slot_src,
  input  logic [SRC_N-1:0]            irq_stat,
  input  logic [LW-1:0]               cur_lvl,
  output logic                        irq_req,
  output logic                        hit_any,
  output logic [LW-1:0]               best
);
  localparam logic [LW-1:0] LVL_IDLE = LW'(NUM_SLOTS + 1);

  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] above;

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
    assign hit[j]   = slot_en[j] & irq_stat[slot_src[j]];
    assign above[j] = LW'(j) < cur_lvl;
  end

  always_comb begin
    best = '0;
    for (int j = NUM_SLOTS - 1; j >= 0; j--) begin
      if (hit[j]) best = LW'(j);
    end
  end

  assign hit_any = |hit;
  assign irq_req = (cur_lvl == LVL_IDLE) ? (|irq_stat) : (|(hit & above));
endmodule

// File: rtl/vic_lvl_stack.sv
module vic_lvl_stack #(
  parameter int NUM_SLOTS = 16,
  parameter int LW        = $clog2(NUM_SLOTS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] cur_lvl
);
  localparam int NLV = NUM_SLOTS + 1;
  localparam logic [LW-1:0] LVL_IDLE = LW'(NUM_SLOTS + 1);

  logic [LW-1:0] saved [NLV];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= LVL_IDLE;
      for (int i = 0; i < NLV; i++) saved[i] <= LVL_IDLE;
    end else if (push) begin
      saved[push_lvl] <= cur_lvl;
      cur_lvl         <= push_lvl;
    end else if (pop && cur_lvl != LVL_IDLE) begin
      cur_lvl <= saved[cur_lvl];
    end
  end
endmodule

// File: rtl/vic_nest_top.sv
module vic_nest_top #(
  parameter int NUM_SLOTS = 16,
  parameter int DW        = 32,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [31:0]   src_req,
  output logic          irq_o,
  output logic          fiq_o
);
  import vic_pkg::*;
  localparam int LW = $clog2(NUM_SLOTS + 2);
  localparam int WI = AW - 2;
  localparam logic [LW-1:0] LVL_DEF  = LW'(NUM_SLOTS);
  localparam logic [LW-1:0] LVL_IDLE = LW'(NUM_SLOTS + 1);
  localparam logic [WI-1:0] W_IRQST = WI'(0),  W_FIQST = WI'(1), W_RAW = WI'(2),
                            W_SEL   = WI'(3),  W_ENS   = WI'(4), W_ENC = WI'(5),
                            W_SFS   = WI'(6),  W_SFC   = WI'(7), W_PROT = WI'(8),
                            W_VEC   = WI'(12), W_DEF   = WI'(13);
  localparam int SLOT_A_BASE = 'h100 >> 2;
  localparam int SLOT_C_BASE = 'h200 >> 2;
  localparam int ID_BASE     = 'hFE0 >> 2;

  logic [31:0] en_q, sel_q, soft_q;
  logic        prot_q;
  logic [DW-1:0] def_q;
  logic [DW-1:0] slot_addr [NUM_SLOTS];
  logic [CTL_W-1:0] slot_ctl [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_en;
  logic [NUM_SLOTS-1:0][SRC_SELW-1:0] slot_src;

  logic [31:0] raw, irq_stat, fiq_stat;
  logic [WI-1:0] widx;
  logic irq_req, hit_any, push, pop, vec_rd;
  logic [LW-1:0] best, cur_lvl, push_lvl, new_lvl;
  logic [DW-1:0] rd_mux, vec_val;

  assign widx     = addr[AW-1:2];
  assign raw      = src_req | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & sel_q;

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_ctl
    assign slot_en[j]  = slot_ctl[j][CTL_W-1];
    assign slot_src[j] = slot_ctl[j][SRC_SELW-1:0];
  end

  vic_slot_arb #(.NUM_SLOTS(NUM_SLOTS), .SRC_N(SRC_N), .SW(SRC_SELW), .LW(LW)) u_arb (
    .slot_en(slot_en), .slot_src(slot_src), .irq_stat(irq_stat), .cur_lvl(cur_lvl),
    .irq_req(irq_req), .hit_any(hit_any), .best(best)
  );

  vic_lvl_stack #(.NUM_SLOTS(NUM_SLOTS), .LW(LW)) u_stk (
    .clk(clk), .rst(rst), .push(push), .push_lvl(push_lvl), .pop(pop), .cur_lvl(cur_lvl)
  );

  // Vector read: raise level to the best pending slot, or to the default level
  always_comb begin
    vec_rd   = rd_en && (widx == W_VEC);
    push     = 1'b0;
    push_lvl = best;
    if (vec_rd) begin
      if (hit_any && best < cur_lvl) begin
        push = 1'b1;
      end else if (!hit_any && (|irq_stat) && cur_lvl == LVL_IDLE) begin
        push     = 1'b1;
        push_lvl = LVL_DEF;
      end
    end
    new_lvl = push ? push_lvl : cur_lvl;
    vec_val = (new_lvl < LVL_DEF) ? slot_addr[new_lvl[$clog2(NUM_SLOTS)-1:0]] : def_q;
  end
  assign pop = wr_en && (widx == W_VEC) && !vec_rd;

  always_comb begin
    rd_mux = '0;
    case (widx)
      W_IRQST: rd_mux = DW'(irq_stat);
      W_FIQST: rd_mux = DW'(fiq_stat);
      W_RAW:   rd_mux = DW'(raw);
      W_SEL:   rd_mux = DW'(sel_q);
      W_ENS:   rd_mux = DW'(en_q);
      W_SFS:   rd_mux = DW'(soft_q);
      W_PROT:  rd_mux = DW'(prot_q);
      W_VEC:   rd_mux = vec_val;
      W_DEF:   rd_mux = def_q;
      default: rd_mux = '0;
    endcase
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (int'(widx) == SLOT_A_BASE + n) rd_mux = slot_addr[n];
      if (int'(widx) == SLOT_C_BASE + n) rd_mux = DW'(slot_ctl[n]);
    end
    for (int k = 0; k < 8; k++) begin
      if (int'(widx) == ID_BASE + k) rd_mux = DW'(ID_BYTES[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; sel_q <= '0; soft_q <= '0; prot_q <= 1'b0; def_q <= '0;
      rdata <= '0; irq_o <= 1'b0; fiq_o <= 1'b0;
      for (int n = 0; n < NUM_SLOTS; n++) begin
        slot_addr[n] <= '0;
        slot_ctl[n]  <= '0;
      end
    end else begin
      irq_o <= irq_req;
      fiq_o <= |fiq_stat;
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        case (widx)
          W_SEL:  sel_q  <= wdata[31:0];
          W_ENS:  en_q   <= en_q | wdata[31:0];
          W_ENC:  en_q   <= en_q & ~wdata[31:0];
          W_SFS:  soft_q <= soft_q | wdata[31:0];
          W_SFC:  soft_q <= soft_q & ~wdata[31:0];
          W_PROT: prot_q <= wdata[0];
          W_DEF:  def_q  <= wdata;
          default: ;
        endcase
        for (int n = 0; n < NUM_SLOTS; n++) begin
          if (int'(widx) == SLOT_A_BASE + n) slot_addr[n] <= wdata;
          if (int'(widx) == SLOT_C_BASE + n) slot_ctl[n]  <= wdata[CTL_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/vic_nest_chk.sv
module vic_nest_chk #(
  parameter int LW = 5,
  parameter int NUM_SLOTS = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic [11:0]   addr,
  input logic [LW-1:0] cur_lvl,
  input logic [31:0]   irq_stat,
  input logic [31:0]   fiq_stat,
  input logic [31:0]   en_q,
  input logic [31:0]   sel_q,
  input logic [31:0]   soft_q,
  input logic          irq_o,
  input logic          fiq_o
);
  // R4: the level never leaves 0..idle
  a_r4_level_bounded: assert property (@(posedge clk) disable iff (rst)
    cur_lvl <= LW'(NUM_SLOTS + 1));
  // R6: a vector read never lowers the priority (never raises the level number)
  a_r6_read_raises: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[11:2] == 10'd12) |=> cur_lvl <= $past(cur_lvl));
  // R8: a vector write below idle returns to a lower-priority level
  a_r8_pop_lowers: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr[11:2] == 10'd12 && cur_lvl != LW'(NUM_SLOTS + 1))
      |=> cur_lvl > $past(cur_lvl));
  // R5: the normal line only rises when some IRQ-status bit was set
  a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|irq_stat));
  // R2: the fast line follows FIQ status
  a_r2_fiq_follows: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|fiq_stat));
  // R10: a write to offset 0 leaves the masks untouched
  a_r10_wr0_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[11:2] == 10'd0) |=> ($stable(en_q) && $stable(sel_q) && $stable(soft_q)));
endmodule

bind vic_nest_top vic_nest_chk #(.LW(LW), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .cur_lvl(cur_lvl),
  .irq_stat(irq_stat), .fiq_stat(fiq_stat), .en_q(en_q), .sel_q(sel_q), .soft_q(soft_q),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/sim_vic_nest_top.sv
module sim_vic_nest_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, src_req = '0;
  logic irq_o, fiq_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vic_nest_top u0 (.clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_req(src_req), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    chk("R11 irq_o after reset", 32'(irq_o), 0);
    chk("R11 fiq_o after reset", 32'(fiq_o), 0);
    rd(12'h010, d); chk("R11 enable zero", d, 0);
    rd(12'h034, d); chk("R11 default zero", d, 0);
    rd(12'h204, d); chk("R11 slot ctl zero", d, 0);
    rd(12'h020, d); chk("R11 protection zero", d, 0);
    rd(12'h030, d); chk("R4 R7 idle vector read gives default", d, 0);
  endtask

  task automatic t_id_undef();
    logic [31:0] d;
    logic [7:0] idv [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), d); chk("R10 id byte", d, 32'(idv[k]));
    end
    rd(12'h03C, d); chk("R10 undefined offset", d, 0);
    wr(12'h020, 32'h3); rd(12'h020, d); chk("R11 protection bit0", d, 1);
  endtask

  task automatic t_raw_soft();
    logic [31:0] d;
    src_req = 32'h5;
    wr(12'h018, 32'h30); wr(12'h018, 32'h100);
    rd(12'h008, d); chk("R1 raw OR", d, 32'h135);
    wr(12'h01C, 32'h110);
    rd(12'h018, d); chk("R1 soft clear", d, 32'h20);
    rd(12'h008, d); chk("R1 raw after clear", d, 32'h25);
    wr(12'h01C, 32'hFFFF_FFFF); src_req = 0;
  endtask

  task automatic t_status_fiq();
    logic [31:0] d;
    wr(12'h010, 32'h0F); wr(12'h014, 32'h02);
    rd(12'h010, d); chk("R3 enable set/clear", d, 32'h0D);
    wr(12'h00C, 32'h08);
    src_req = 32'h0E; settle();
    rd(12'h000, d); chk("R2 irq status", d, 32'h04);
    rd(12'h004, d); chk("R2 fiq status", d, 32'h08);
    chk("R2 fiq_o high", 32'(fiq_o), 1);
    chk("R5 irq_o idle with status", 32'(irq_o), 1);
    src_req = 32'h06; settle();
    chk("R2 fiq_o low", 32'(fiq_o), 0);
    src_req = 0; wr(12'h00C, 0); wr(12'h014, 32'hFFFF_FFFF); settle();
    chk("R5 irq_o low no status", 32'(irq_o), 0);
  endtask

  task automatic t_nesting();
    logic [31:0] d;
    wr(12'h200, 32'h20 | 3); wr(12'h100, 32'hA000);
    wr(12'h204, 32'h20 | 7); wr(12'h104, 32'hB000);
    wr(12'h034, 32'hDEF0); rd(12'h034, d); chk("R9 default rw", d, 32'hDEF0);
    rd(12'h204, d); chk("R4 slot ctl readback", d, 32'h27);
    wr(12'h010, 32'h0488);
    src_req = 32'h80; settle();
    chk("R5 irq_o idle src7", 32'(irq_o), 1);
    rd(12'h030, d); chk("R6 read slot1 addr", d, 32'hB000);
    settle(); chk("R5 irq_o masked at level1", 32'(irq_o), 0);
    src_req = 32'h88; settle();
    chk("R5 irq_o slot0 preempts", 32'(irq_o), 1);
    rd(12'h030, d); chk("R6 nested read slot0", d, 32'hA000);
    settle(); chk("R5 irq_o low at level0", 32'(irq_o), 0);
    rd(12'h030, d); chk("R6 no outranking keeps level", d, 32'hA000);
    wr(12'h030, 32'h1234); settle();
    chk("R8 pop to level1 src3 pending", 32'(irq_o), 1);
    src_req = 32'h80; settle();
    chk("R8 level1 blocks src7", 32'(irq_o), 0);
    rd(12'h030, d); chk("R8 level1 address", d, 32'hB000);
    wr(12'h030, 32'h0); settle();
    chk("R8 pop to idle", 32'(irq_o), 1);
    src_req = 0; settle();
    rd(12'h030, d); chk("R7 nothing pending default", d, 32'hDEF0);
    wr(12'h030, 0); settle();
    chk("R8 write at idle harmless", 32'(irq_o), 0);
  endtask

  task automatic t_unassigned();
    logic [31:0] d;
    src_req = 32'h400; settle();
    chk("R5 unassigned at idle", 32'(irq_o), 1);
    rd(12'h030, d); chk("R7 unassigned gives default", d, 32'hDEF0);
    settle(); chk("R7 default level masks unassigned", 32'(irq_o), 0);
    src_req = 32'h408; settle();
    chk("R5 slot preempts default level", 32'(irq_o), 1);
    src_req = 32'h400;
    wr(12'h000, 32'hFFFF_FFFF); settle();
    chk("R10 write 0 ignored irq", 32'(irq_o), 0);
    rd(12'h010, d); chk("R10 write 0 keeps enable", d, 32'h0488);
    wr(12'h030, 0); settle();
    chk("R8 default level pops to idle", 32'(irq_o), 1);
    src_req = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset(); t_id_undef(); t_raw_soft(); t_status_fiq(); t_nesting(); t_unassigned();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule